// File: doc/BRIEF.md
# Encoder Input Polarity and Source Router

This block conditions the signals that feed one motion channel's quadrature counter and pulse generator. Every off-chip input (the two encoder phases, the index pulse, the capture trigger, the stop switch and the way-point switches) is brought into the clock domain through a two-flop synchronizer. A polarity register can then invert each of them. A source register chooses what drives each of the counter's four inputs. The two count inputs can take the external phases, the channel's own step and direction outputs (for loopback counting), the index pulse, or a fixed level. The two active-low control inputs can take capture, stop, their combination, or a fixed inactive level.

Both configuration registers are seven bits wide, sit in an eight-bit window, and are written and read over a one-strobe register bus. All routed outputs are registered, so the counter and pulse generator see glitch-free levels. Input changes appear three clock edges after they are applied, and loopback or configuration changes appear one edge after the write or change.

Top module: `enc_input_router`

## Requirements
- R1: While reset is asserted, both registers read 0, cnt_a and cnt_b are 0, pg_index is 0, and cnt_rst_gate_n, cnt_load_n, estop_n and every pg_waypt_n bit are 1.
- R2: reg_sel 0 addresses the polarity register and reg_sel 1 addresses the source register. A write with reg_wr high at a rising edge is visible on reg_rdata, which shows the selected register, from the next cycle on. Bit 7 always reads 0.
- R3: Polarity bit 0 inverts the count A path, bit 1 inverts the count B path, bit 2 inverts capture, bit 4 inverts all way-point lines, bit 5 inverts index and bit 6 inverts stop. Bit 3 is the capture enable.
- R4: Source bits 1..0 pick the count A signal: 00 external A, 01 step_out, 10 index after its own inversion, 11 constant 1. For the first three choices, the A inversion is applied to the picked signal. The constant is never inverted.
- R5: Source bit 2 picks the count B signal: 0 external B, 1 dir_out. The B inversion is applied to the picked signal.
- R6: Source bits 4..3 pick cnt_rst_gate_n: 00 capture term, 01 stop after inversion, 10 asserted (0) when either the capture term or the inverted stop is 0, 11 constant 1.
- R7: Source bits 6..5 pick cnt_load_n with the same encoding as R6, independently of it.
- R8: With polarity bit 3 at 0, the capture term is 1 whatever ext_capture does. With bit 3 at 1, the capture term is ext_capture xor polarity bit 2.
- R9: pg_waypt_n, pg_index and estop_n follow the synchronized way-point, index and stop inputs, each xor its inversion bit.
- R10: An external input change reaches the outputs at the third rising edge after it is applied. A change of step_out or dir_out, or a register write, reaches them at the next rising edge after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 polarity, 1 source |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_a | input | 1 | External encoder phase A |
| ext_b | input | 1 | External encoder phase B |
| ext_index | input | 1 | External index pulse |
| ext_capture | input | 1 | External capture trigger |
| ext_stop | input | 1 | External stop switch |
| ext_waypt | input | WP_W | External way-point switches |
| step_out | input | 1 | Channel's own step pulse output (same clock domain) |
| dir_out | input | 1 | Channel's own direction output (same clock domain) |
| cnt_a | output | 1 | Counter count input A |
| cnt_b | output | 1 | Counter count input B |
| cnt_rst_gate_n | output | 1 | Counter reset/gate control, active low |
| cnt_load_n | output | 1 | Counter load/latch control, active low |
| pg_waypt_n | output | WP_W | Way-point lines to the pulse generator, active low |
| pg_index | output | 1 | Index line to the pulse generator |
| estop_n | output | 1 | Stop line to the interrupt logic, active low |

## Verification
Two things can happen in the same cycle: a register write changes a routing or inversion choice, and the routed input signals change value. The bench provokes this on every step of a sweep over all 128 polarity values and all 128 source values. At each step it writes both registers in the cycles in which fresh values are applied to all external inputs and to step_out and dir_out. It then checks that the outputs reflect the new configuration combined with the new inputs, and never a mix of old and new. Each output is compared against a value the bench computes from the encodings in the requirements. Separate edge-counted tests then pin down the three-edge input latency, the one-edge loopback latency and the capture-disable case.

// File: rtl/eir_pkg.sv
package eir_pkg;

  localparam int unsigned CFG_W    = 8;
  localparam int unsigned FIELD_W  = CFG_W - 1;
  localparam logic [CFG_W-1:0] CFG_MASK = 8'h7F;

  typedef enum logic [1:0] {
    A_EXT   = 2'b00,
    A_STEP  = 2'b01,
    A_INDEX = 2'b10,
    A_HIGH  = 2'b11
  } a_src_e;

  typedef enum logic [1:0] {
    CT_CAPT   = 2'b00,
    CT_STOP   = 2'b01,
    CT_EITHER = 2'b10,
    CT_IDLE   = 2'b11
  } ctl_src_e;

  typedef struct packed {
    logic stop_inv;
    logic idx_inv;
    logic wp_inv;
    logic cap_en;
    logic cap_inv;
    logic b_inv;
    logic a_inv;
  } pol_cfg_t;

  typedef struct packed {
    ctl_src_e ld_sel;
    ctl_src_e rg_sel;
    logic     b_dir;
    a_src_e   a_sel;
  } src_cfg_t;

endpackage

// File: rtl/eir_sync.sv
module eir_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/eir_cfg_regs.sv
module eir_cfg_regs
  import eir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             sel,
  input  logic [CFG_W-1:0] wdata,
  output pol_cfg_t         pol_q,
  output src_cfg_t         src_q,
  output logic [CFG_W-1:0] rdata
);

  logic [CFG_W-1:0] pol_raw_q, pol_raw_d;
  logic [CFG_W-1:0] src_raw_q, src_raw_d;
  logic             pol_we, src_we;

  assign pol_we = wr_en && (sel == 1'b0);
  assign src_we = wr_en && (sel == 1'b1);

  always_comb begin
    pol_raw_d = pol_raw_q;
    src_raw_d = src_raw_q;
    if (pol_we) pol_raw_d = wdata & CFG_MASK;
    if (src_we) src_raw_d = wdata & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_raw_q <= '0;
      src_raw_q <= '0;
    end else begin
      pol_raw_q <= pol_raw_d;
      src_raw_q <= src_raw_d;
    end
  end

  assign pol_q = pol_cfg_t'(pol_raw_q[FIELD_W-1:0]);
  assign src_q = src_cfg_t'(src_raw_q[FIELD_W-1:0]);
  assign rdata = sel ? src_raw_q : pol_raw_q;

endmodule

// File: rtl/eir_route.sv
module eir_route
  import eir_pkg::*;
#(
  parameter int unsigned WP_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pol_cfg_t        pol,
  input  src_cfg_t        src,
  input  logic            a_s,
  input  logic            b_s,
  input  logic            idx_s,
  input  logic            cap_s,
  input  logic            stop_s,
  input  logic [WP_W-1:0] wp_s,
  input  logic            step_i,
  input  logic            dir_i,
  output logic            cnt_a,
  output logic            cnt_b,
  output logic            cnt_rst_gate_n,
  output logic            cnt_load_n,
  output logic [WP_W-1:0] pg_waypt_n,
  output logic            pg_index,
  output logic            estop_n
);

  logic            idx_c, stop_c, cap_c;
  logic            a_d, b_d, rg_d, ld_d, idx_d, stop_d;
  logic [WP_W-1:0] wp_d;

  function automatic logic pick_ctl(input ctl_src_e s, input logic capt, input logic stp);
    logic r;
    unique case (s)
      CT_CAPT:   r = capt;
      CT_STOP:   r = stp;
      CT_EITHER: r = capt & stp;
      CT_IDLE:   r = 1'b1;
    endcase
    return r;
  endfunction

  always_comb begin
    idx_c = idx_s ^ pol.idx_inv;
    stop_c = stop_s ^ pol.stop_inv;
    cap_c = pol.cap_en ? (cap_s ^ pol.cap_inv) : 1'b1;

    unique case (src.a_sel)
      A_EXT:   a_d = a_s ^ pol.a_inv;
      A_STEP:  a_d = step_i ^ pol.a_inv;
      A_INDEX: a_d = idx_c ^ pol.a_inv;
      A_HIGH:  a_d = 1'b1;
    endcase

    b_d = (src.b_dir ? dir_i : b_s) ^ pol.b_inv;
    rg_d = pick_ctl(src.rg_sel, cap_c, stop_c);
    ld_d = pick_ctl(src.ld_sel, cap_c, stop_c);
    wp_d = wp_s ^ {WP_W{pol.wp_inv}};
    idx_d = idx_c;
    stop_d = stop_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a          <= 1'b0;
      cnt_b          <= 1'b0;
      cnt_rst_gate_n <= 1'b1;
      cnt_load_n     <= 1'b1;
      pg_waypt_n     <= '1;
      pg_index       <= 1'b0;
      estop_n        <= 1'b1;
    end else begin
      cnt_a          <= a_d;
      cnt_b          <= b_d;
      cnt_rst_gate_n <= rg_d;
      cnt_load_n     <= ld_d;
      pg_waypt_n     <= wp_d;
      pg_index       <= idx_d;
      estop_n        <= stop_d;
    end
  end

endmodule

// File: rtl/enc_input_router.sv
module enc_input_router
  import eir_pkg::*;
#(
  parameter int unsigned WP_W        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CFG_W-1:0] reg_wdata,
  output logic [CFG_W-1:0] reg_rdata,
  input  logic             ext_a,
  input  logic             ext_b,
  input  logic             ext_index,
  input  logic             ext_capture,
  input  logic             ext_stop,
  input  logic [WP_W-1:0]  ext_waypt,
  input  logic             step_out,
  input  logic             dir_out,
  output logic             cnt_a,
  output logic             cnt_b,
  output logic             cnt_rst_gate_n,
  output logic             cnt_load_n,
  output logic [WP_W-1:0]  pg_waypt_n,
  output logic             pg_index,
  output logic             estop_n
);

  localparam int unsigned IN_W = 5 + WP_W;

  logic [1:0]      rst_pipe_q, rst_pipe_d;
  logic            rst_sync_n;
  logic [IN_W-1:0] in_raw, in_sync;
  pol_cfg_t        pol_q;
  src_cfg_t        src_q;

  always_comb begin
    rst_pipe_d = {rst_pipe_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  assign in_raw = {ext_waypt, ext_stop, ext_capture, ext_index, ext_b, ext_a};

  eir_sync #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (in_raw),
    .q     (in_sync)
  );

  eir_cfg_regs i_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (reg_wr),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .pol_q (pol_q),
    .src_q (src_q),
    .rdata (reg_rdata)
  );

  eir_route #(
    .WP_W (WP_W)
  ) i_route (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .pol            (pol_q),
    .src            (src_q),
    .a_s            (in_sync[0]),
    .b_s            (in_sync[1]),
    .idx_s          (in_sync[2]),
    .cap_s          (in_sync[3]),
    .stop_s         (in_sync[4]),
    .wp_s           (in_sync[IN_W-1:5]),
    .step_i         (step_out),
    .dir_i          (dir_out),
    .cnt_a          (cnt_a),
    .cnt_b          (cnt_b),
    .cnt_rst_gate_n (cnt_rst_gate_n),
    .cnt_load_n     (cnt_load_n),
    .pg_waypt_n     (pg_waypt_n),
    .pg_index       (pg_index),
    .estop_n        (estop_n)
  );

endmodule

// File: rtl/enc_input_router_chk.sv
module enc_input_router_chk
  import eir_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [CFG_W-1:0] reg_wdata,
  input logic [CFG_W-1:0] reg_rdata,
  input pol_cfg_t         pol_q,
  input src_cfg_t         src_q,
  input logic             dir_out,
  input logic             cnt_a,
  input logic             cnt_b,
  input logic             cnt_rst_gate_n,
  input logic             cnt_load_n
);

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr |=> (reg_sel != $past(reg_sel)) || (reg_rdata == ($past(reg_wdata) & CFG_MASK)));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !reg_wr |=> (reg_sel != $past(reg_sel)) || $stable(reg_rdata));

  // R4
  a_const_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_q.a_sel == A_HIGH) |=> cnt_a);

  // R5
  b_loop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    src_q.b_dir |=> (cnt_b == ($past(dir_out) ^ $past(pol_q.b_inv))));

  // R6
  rg_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_q.rg_sel == CT_IDLE) |=> cnt_rst_gate_n);

  // R7
  ld_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src_q.ld_sel == CT_IDLE) |=> cnt_load_n);

  // R8
  cap_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pol_q.cap_en && src_q.rg_sel == CT_CAPT && src_q.ld_sel == CT_CAPT)
      |=> (cnt_rst_gate_n && cnt_load_n));

endmodule

bind enc_input_router enc_input_router_chk i_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .reg_wr         (reg_wr),
  .reg_sel        (reg_sel),
  .reg_wdata      (reg_wdata),
  .reg_rdata      (reg_rdata),
  .pol_q          (pol_q),
  .src_q          (src_q),
  .dir_out        (dir_out),
  .cnt_a          (cnt_a),
  .cnt_b          (cnt_b),
  .cnt_rst_gate_n (cnt_rst_gate_n),
  .cnt_load_n     (cnt_load_n)
);

// File: tb/test_enc_input_router.sv
module test_enc_input_router;

  localparam int CLK_PERIOD = 10;
  localparam int WP_W = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  logic ext_a, ext_b, ext_index, ext_capture, ext_stop;
  logic [WP_W-1:0] ext_waypt;
  logic step_out, dir_out;
  logic cnt_a, cnt_b, cnt_rst_gate_n, cnt_load_n, pg_index, estop_n;
  logic [WP_W-1:0] pg_waypt_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  enc_input_router #(.WP_W(WP_W)) i_enc_input_router (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_a(ext_a), .ext_b(ext_b), .ext_index(ext_index), .ext_capture(ext_capture),
    .ext_stop(ext_stop), .ext_waypt(ext_waypt),
    .step_out(step_out), .dir_out(dir_out),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_rst_gate_n(cnt_rst_gate_n), .cnt_load_n(cnt_load_n),
    .pg_waypt_n(pg_waypt_n), .pg_index(pg_index), .estop_n(estop_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] observed();
    return {cnt_a, cnt_b, cnt_rst_gate_n, cnt_load_n, pg_waypt_n, pg_index, estop_n};
  endfunction

  // Expected output bundle from the encodings of R3..R9.
  // in = {a, b, idx, cap, stop, wp[1:0], step, dir}
  function automatic logic [8:0] model(input logic [6:0] p, input logic [6:0] s, input logic [8:0] in);
    logic a, b, idx, cap, stp, step, dir;
    logic [1:0] wp;
    logic idx_c, stop_c, cap_c, oa, ob, org, old;
    {a, b, idx, cap, stp, wp, step, dir} = in;
    idx_c  = idx ^ p[5];
    stop_c = stp ^ p[6];
    cap_c  = p[3] ? (cap ^ p[2]) : 1'b1;
    case (s[1:0])
      2'd0: oa = a ^ p[0];
      2'd1: oa = step ^ p[0];
      2'd2: oa = idx_c ^ p[0];
      default: oa = 1'b1;
    endcase
    ob = (s[2] ? dir : b) ^ p[1];
    case (s[4:3])
      2'd0: org = cap_c;
      2'd1: org = stop_c;
      2'd2: org = cap_c & stop_c;
      default: org = 1'b1;
    endcase
    case (s[6:5])
      2'd0: old = cap_c;
      2'd1: old = stop_c;
      2'd2: old = cap_c & stop_c;
      default: old = 1'b1;
    endcase
    return {oa, ob, org, old, wp ^ {2{p[4]}}, idx_c, stop_c};
  endfunction

  task automatic write_reg(input logic sel, input logic [7:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    ext_a = 1'b0; ext_b = 1'b0; ext_index = 1'b0; ext_capture = 1'b1; ext_stop = 1'b1;
    ext_waypt = '1; step_out = 1'b0; dir_out = 1'b0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outputs", {23'd0, observed()}, {23'd0, 9'b0_0_1_1_11_0_1});
    chk("R1 polarity read", {24'd0, reg_rdata}, 32'd0);
    reg_sel = 1'b1;
    #1;
    chk("R1 source read", {24'd0, reg_rdata}, 32'd0);
    reg_sel = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: bit 7 never stored
    write_reg(1'b0, 8'hFF);
    chk("R2 polarity readback bit7", {24'd0, reg_rdata}, 32'h7F);
    write_reg(1'b1, 8'hD5);
    chk("R2 source readback bit7", {24'd0, reg_rdata}, 32'h55);
    reg_sel = 1'b0;
    #1;
    chk("R2 polarity kept", {24'd0, reg_rdata}, 32'h7F);

    // Sweep R3 R4 R5 R6 R7 R8 R9: config writes land in the cycles new inputs arrive
    for (int k = 0; k < 16384; k++) begin
      logic [6:0] p, s;
      logic [31:0] h;
      logic [8:0] vec;
      p = k[6:0];
      s = k[13:7];
      h = k * 73 + 5 + (k >> 5);
      vec = h[8:0] ^ {h[3:0], h[14:10]};
      @(negedge clk);
      {ext_a, ext_b, ext_index, ext_capture, ext_stop, ext_waypt, step_out, dir_out} = vec;
      reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = {vec[0], p};
      @(negedge clk);
      reg_sel = 1'b1; reg_wdata = {vec[1], s};
      @(negedge clk);
      reg_wr = 1'b0;
      @(negedge clk);
      chk("R3 R4 R5 R6 R7 R8 R9 routing", {23'd0, observed()}, {23'd0, model(p, s, vec)});
      chk("R2 source readback", {24'd0, reg_rdata}, {25'd0, s});
    end

    // R10: external input reaches the outputs at the third edge
    write_reg(1'b0, 8'h00);
    write_reg(1'b1, 8'h00);
    ext_a = 1'b0;
    repeat (4) @(negedge clk);
    ext_a = 1'b1;
    @(negedge clk);
    chk("R10 edge1 cnt_a", {31'd0, cnt_a}, 32'd0);
    @(negedge clk);
    chk("R10 edge2 cnt_a", {31'd0, cnt_a}, 32'd0);
    @(negedge clk);
    chk("R10 edge3 cnt_a", {31'd0, cnt_a}, 32'd1);

    // R10 / R4: loopback step reaches cnt_a at the next edge
    write_reg(1'b1, 8'h01);
    step_out = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 step low", {31'd0, cnt_a}, 32'd0);
    step_out = 1'b1;
    @(negedge clk);
    chk("R10 step loopback edge1", {31'd0, cnt_a}, 32'd1);

    // R8: capture disabled has no effect on the control outputs
    write_reg(1'b0, 8'h00);
    write_reg(1'b1, 8'h00);
    for (int t = 0; t < 8; t++) begin
      ext_capture = t[0];
      @(negedge clk);
      chk("R8 capture gated rst_gate", {31'd0, cnt_rst_gate_n}, 32'd1);
      chk("R8 capture gated load", {31'd0, cnt_load_n}, 32'd1);
    end
    ext_capture = 1'b0;
    write_reg(1'b0, 8'h08);
    repeat (3) @(negedge clk);
    chk("R8 capture enabled", {31'd0, cnt_rst_gate_n}, 32'd0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule